// File: doc/BRIEF.md
# I2C Interrupt Status Aggregator

This block gathers the event strobes of an I2C controller's shift engine into three sticky status flags and merges them into a single registered interrupt request for the system interrupt controller. The three flags are transmit-register-empty, receive-byte-full and own-address-hit. A latched direction flag records whether the last matching slave address asked for a read. The host clears the flags by reading the status register, or by accessing the data register that each flag belongs to.

The shift engine drives single-cycle strobes. The first bit of a 10-bit address going out, the first bit of the last address byte going out, and the first bit of a data byte going out feed the transmit flag. A completed received byte, marked as address or data and carrying the match result when it is an address, feeds the receive and address flags. While the controller is disabled, none of the flags can be set. In that state the baud-rate generator tick passes straight to the interrupt line, so the controller can serve as a plain timer.

All ports are plain control and status signals. There is no data stream and no back-pressure.

Top module: `i2c_irq_status`

## Requirements
- R1: Out of reset, tx_empty, rx_full, addr_hit, dir_read and irq are all 0.
- R2: tx_empty becomes 1 on the clock after a cycle in which ctl_enable=1 and txe_irq_en=1 and one of three things happens. The first case is ev_data_first=1. The second case is ev_addr10_first=1 while the transmit register is empty. The third case is ev_addr_last_first=1 with ev_addr_rd=0 while the transmit register is empty. The transmit register is filled by host_data_wr and emptied by ev_data_first.
- R3: host_data_wr clears tx_empty to 0 on the next clock, even when a set condition occurs in the same cycle.
- R4: In master mode (mode_slave=0), a received byte with ev_byte_is_addr=0 sets rx_full, and host_data_rd clears it.
- R5: In slave mode with mode_all_rx=0, a received address byte does not set rx_full. A received data byte sets rx_full only when the most recent received address matched. With mode_all_rx=1, every received byte sets rx_full.
- R6: In slave mode, a received address byte with ev_addr_match=1 sets addr_hit and loads dir_read from ev_match_rd.
- R7: host_status_rd clears tx_empty, rx_full and addr_hit. A set condition for a flag in the same cycle wins, and that flag reads 1.
- R8: While ctl_enable=1, irq on each clock becomes the OR of (tx_empty AND txe_irq_en), rx_full and addr_hit, using the flag values before that clock.
- R9: While ctl_enable=0, no flag is set, and irq on each clock takes the value brg_tick had in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enable |
| txe_irq_en | input | 1 | Enables the transmit-empty flag and its interrupt |
| mode_slave | input | 1 | 1 = slave mode, 0 = master mode |
| mode_all_rx | input | 1 | Flag every received address and data byte in slave mode |
| ev_data_first | input | 1 | First bit of a data byte shifted out |
| ev_addr10_first | input | 1 | First bit of a 10-bit address shifted out |
| ev_addr_last_first | input | 1 | First bit of the final address byte shifted out |
| ev_addr_rd | input | 1 | Direction bit of the address being sent (1 = read) |
| ev_byte_rx | input | 1 | A byte has been received |
| ev_byte_is_addr | input | 1 | The received byte is an address byte |
| ev_addr_match | input | 1 | The received address matched the own address |
| ev_match_rd | input | 1 | Direction bit of the received address |
| host_status_rd | input | 1 | Host reads the status register |
| host_data_rd | input | 1 | Host reads the data register |
| host_data_wr | input | 1 | Host writes the data register |
| brg_tick | input | 1 | Baud-rate generator tick |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| addr_hit | output | 1 | Own-address-hit flag |
| dir_read | output | 1 | Direction of the last matching address |
| irq | output | 1 | Combined interrupt request |

## Verification
Directed sequences build slave transactions from scratch. The first is a matching address followed by data. The second is a non-matching address followed by data. The third repeats these with all-bytes mode on. Together they separate the match-tracking state from the per-byte rule. Colliding strobes, such as a status read landing on a byte arrival or a data write landing on a data-first strobe, show which side of each priority the design takes. Long runs of seeded random strobes, with the enable and mode bits toggling, compare every output each cycle against a bench model. These runs expose mix-ups between the address-event gating on register occupancy and the ungated data-event path, and they check the one-cycle interrupt latency in both the enabled and the timer state.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_TX   = 2'd0,
    SRC_RX   = 2'd1,
    SRC_ADDR = 2'd2
  } src_idx_e;

  typedef struct packed {
    logic data_first;
    logic addr10_first;
    logic addr_last_first;
    logic addr_rd;
  } tx_evt_t;

  typedef struct packed {
    logic byte_rx;
    logic is_addr;
    logic match;
    logic match_rd;
  } rx_evt_t;
endpackage

// File: rtl/irq_tx_flag.sv
module irq_tx_flag
  import i2c_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    irq_en,
  input  tx_evt_t evt,
  input  logic    host_wr,
  input  logic    status_rd,
  output logic    flag
);
  logic buf_full;
  logic addr_evt;
  logic set_cond;

  // occupancy of the transmit holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              buf_full <= 1'b0;
    else if (host_wr)        buf_full <= 1'b1;
    else if (evt.data_first) buf_full <= 1'b0;
  end

  always_comb begin
    addr_evt = evt.addr10_first | (evt.addr_last_first & ~evt.addr_rd);
    set_cond = enable & irq_en & (evt.data_first | (~buf_full & addr_evt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (host_wr)   flag <= 1'b0;
    else if (set_cond)  flag <= 1'b1;
    else if (status_rd) flag <= 1'b0;
  end
endmodule

// File: rtl/irq_rx_flag.sv
module irq_rx_flag
  import i2c_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    slave,
  input  logic    all_rx,
  input  rx_evt_t evt,
  input  logic    data_rd,
  input  logic    status_rd,
  output logic    flag
);
  logic matched;
  logic addr_byte;
  logic allowed;
  logic set_cond;

  always_comb begin
    addr_byte = enable & slave & evt.byte_rx & evt.is_addr;
    allowed   = slave ? (all_rx | (~evt.is_addr & matched)) : ~evt.is_addr;
    set_cond  = enable & evt.byte_rx & allowed;
  end

  // remembers whether the latest received address was ours
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         matched <= 1'b0;
    else if (addr_byte) matched <= evt.match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flag <= 1'b0;
    else if (set_cond)              flag <= 1'b1;
    else if (data_rd || status_rd)  flag <= 1'b0;
  end
endmodule

// File: rtl/irq_addr_flag.sv
module irq_addr_flag
  import i2c_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    enable,
  input  logic    slave,
  input  rx_evt_t evt,
  input  logic    status_rd,
  output logic    flag,
  output logic    dir_rd
);
  logic hit;

  always_comb hit = enable & slave & evt.byte_rx & evt.is_addr & evt.match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      dir_rd <= 1'b0;
    end else begin
      if (hit)            flag <= 1'b1;
      else if (status_rd) flag <= 1'b0;
      if (hit)            dir_rd <= evt.match_rd;
    end
  end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
  import i2c_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_enable,
  input  logic txe_irq_en,
  input  logic mode_slave,
  input  logic mode_all_rx,
  input  logic ev_data_first,
  input  logic ev_addr10_first,
  input  logic ev_addr_last_first,
  input  logic ev_addr_rd,
  input  logic ev_byte_rx,
  input  logic ev_byte_is_addr,
  input  logic ev_addr_match,
  input  logic ev_match_rd,
  input  logic host_status_rd,
  input  logic host_data_rd,
  input  logic host_data_wr,
  input  logic brg_tick,
  output logic tx_empty,
  output logic rx_full,
  output logic addr_hit,
  output logic dir_read,
  output logic irq
);
  tx_evt_t            tx_evt;
  rx_evt_t            rx_evt;
  logic [NUM_SRC-1:0] src_flag;
  logic [NUM_SRC-1:0] src_mask;
  logic [NUM_SRC-1:0] src_req;

  always_comb begin
    tx_evt = '{data_first: ev_data_first, addr10_first: ev_addr10_first,
               addr_last_first: ev_addr_last_first, addr_rd: ev_addr_rd};
    rx_evt = '{byte_rx: ev_byte_rx, is_addr: ev_byte_is_addr,
               match: ev_addr_match, match_rd: ev_match_rd};
  end

  irq_tx_flag u_tx (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .irq_en(txe_irq_en),
    .evt(tx_evt), .host_wr(host_data_wr), .status_rd(host_status_rd),
    .flag(tx_empty)
  );

  irq_rx_flag u_rx (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .slave(mode_slave),
    .all_rx(mode_all_rx), .evt(rx_evt), .data_rd(host_data_rd),
    .status_rd(host_status_rd), .flag(rx_full)
  );

  irq_addr_flag u_addr (
    .clk(clk), .rst_n(rst_n), .enable(ctl_enable), .slave(mode_slave),
    .evt(rx_evt), .status_rd(host_status_rd),
    .flag(addr_hit), .dir_rd(dir_read)
  );

  always_comb begin
    src_flag = '0;
    src_mask = '1;
    src_flag[SRC_TX]   = tx_empty;
    src_flag[SRC_RX]   = rx_full;
    src_flag[SRC_ADDR] = addr_hit;
    src_mask[SRC_TX]   = txe_irq_en;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_req
      assign src_req[gi] = src_flag[gi] & src_mask[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          irq <= 1'b0;
    else if (ctl_enable) irq <= |src_req;
    else                 irq <= brg_tick;
  end
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_enable,
  input logic txe_irq_en,
  input logic mode_slave,
  input logic mode_all_rx,
  input logic ev_data_first,
  input logic ev_addr10_first,
  input logic ev_addr_last_first,
  input logic ev_byte_rx,
  input logic ev_byte_is_addr,
  input logic ev_addr_match,
  input logic ev_match_rd,
  input logic host_status_rd,
  input logic host_data_rd,
  input logic host_data_wr,
  input logic brg_tick,
  input logic tx_empty,
  input logic rx_full,
  input logic addr_hit,
  input logic dir_read,
  input logic irq
);
  p_tx_needs_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(ev_data_first || ev_addr10_first || ev_addr_last_first));

  p_wr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_wr |=> !tx_empty);

  p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_rd && !ev_byte_rx) |=> !rx_full);

  p_addr_byte_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte_rx && ev_byte_is_addr && mode_slave && !mode_all_rx && !rx_full) |=> !rx_full);

  p_hit_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && mode_slave && ev_byte_rx && ev_byte_is_addr && ev_addr_match)
      |=> (addr_hit && dir_read == $past(ev_match_rd)));

  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status_rd && !ev_byte_rx) |=> (!rx_full && !addr_hit));

  p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enable |=> irq == $past((tx_empty && txe_irq_en) || rx_full || addr_hit));

  p_irq_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> irq == $past(brg_tick));

  p_no_set_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_enable && !tx_empty && !rx_full && !addr_hit) |=> (!tx_empty && !rx_full && !addr_hit));
endmodule

bind i2c_irq_status i2c_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .txe_irq_en(txe_irq_en),
  .mode_slave(mode_slave), .mode_all_rx(mode_all_rx),
  .ev_data_first(ev_data_first), .ev_addr10_first(ev_addr10_first),
  .ev_addr_last_first(ev_addr_last_first), .ev_byte_rx(ev_byte_rx),
  .ev_byte_is_addr(ev_byte_is_addr), .ev_addr_match(ev_addr_match),
  .ev_match_rd(ev_match_rd), .host_status_rd(host_status_rd),
  .host_data_rd(host_data_rd), .host_data_wr(host_data_wr), .brg_tick(brg_tick),
  .tx_empty(tx_empty), .rx_full(rx_full), .addr_hit(addr_hit),
  .dir_read(dir_read), .irq(irq)
);

// File: tb/tb_i2c_irq_status.sv
`timescale 1ns/1ps
module tb_i2c_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_enable, txe_irq_en, mode_slave, mode_all_rx;
  logic ev_data_first, ev_addr10_first, ev_addr_last_first, ev_addr_rd;
  logic ev_byte_rx, ev_byte_is_addr, ev_addr_match, ev_match_rd;
  logic host_status_rd, host_data_rd, host_data_wr, brg_tick;
  logic tx_empty, rx_full, addr_hit, dir_read, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  bit m_tx, m_buf, m_rx, m_hit, m_dir, m_match, m_irq;

  always #2.5 clk = ~clk;

  i2c_irq_status dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr_ev();
    ev_data_first = 0; ev_addr10_first = 0; ev_addr_last_first = 0; ev_addr_rd = 0;
    ev_byte_rx = 0; ev_byte_is_addr = 0; ev_addr_match = 0; ev_match_rd = 0;
    host_status_rd = 0; host_data_rd = 0; host_data_wr = 0; brg_tick = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clr_ev();
    ctl_enable = 1; txe_irq_en = 1; mode_slave = 0; mode_all_rx = 0;
    m_tx = 0; m_buf = 0; m_rx = 0; m_hit = 0; m_dir = 0; m_match = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // advance one clock: inputs already driven, wait to next falling edge
  task automatic step();
    @(negedge clk);
    clr_ev();
  endtask

  function automatic bit rx_allowed(bit slave, bit all, bit is_addr, bit matched);
    if (slave) return all || (!is_addr && matched);
    return !is_addr;
  endfunction

  // state after the next rising edge, from requirements R2..R9
  task automatic model_update();
    bit tx_set, rx_set, hit_set;
    m_irq = ctl_enable ? ((m_tx && txe_irq_en) || m_rx || m_hit) : brg_tick;
    tx_set = ctl_enable && txe_irq_en &&
             (ev_data_first || (!m_buf && (ev_addr10_first || (ev_addr_last_first && !ev_addr_rd))));
    rx_set = ctl_enable && ev_byte_rx && rx_allowed(mode_slave, mode_all_rx, ev_byte_is_addr, m_match);
    hit_set = ctl_enable && mode_slave && ev_byte_rx && ev_byte_is_addr && ev_addr_match;
    if (host_data_wr) m_tx = 0; else if (tx_set) m_tx = 1; else if (host_status_rd) m_tx = 0;
    if (host_data_wr) m_buf = 1; else if (ev_data_first) m_buf = 0;
    if (rx_set) m_rx = 1; else if (host_data_rd || host_status_rd) m_rx = 0;
    if (hit_set) begin m_hit = 1; m_dir = ev_match_rd; end
    else if (host_status_rd) m_hit = 0;
    if (ctl_enable && mode_slave && ev_byte_rx && ev_byte_is_addr) m_match = ev_addr_match;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    do_reset();
    // R1 reset state
    chk("R1 tx_empty", tx_empty, 0); chk("R1 rx_full", rx_full, 0);
    chk("R1 addr_hit", addr_hit, 0); chk("R1 dir_read", dir_read, 0); chk("R1 irq", irq, 0);

    // R2: address event with empty register sets flag; irq one cycle later (R8)
    ev_addr10_first = 1; step();
    chk("R2 addr10 sets", tx_empty, 1);
    step();
    chk("R8 irq follows", irq, 1);
    host_status_rd = 1; step();
    chk("R7 status clears tx", tx_empty, 0);
    // R2: register full blocks address events; R3 write clears
    host_data_wr = 1; step();
    ev_addr_last_first = 1; step();
    chk("R2 full blocks addr", tx_empty, 0);
    ev_data_first = 1; step();
    chk("R2 data_first sets", tx_empty, 1);
    ev_addr_last_first = 1; ev_addr_rd = 1; host_status_rd = 1; step();
    chk("R2 read dir no set", tx_empty, 0);
    ev_data_first = 1; host_data_wr = 1; step();
    chk("R3 write beats set", tx_empty, 0);

    // R4 master receive
    ev_byte_rx = 1; step();
    chk("R4 master data sets", rx_full, 1);
    host_data_rd = 1; step();
    chk("R4 data read clears", rx_full, 0);
    ev_byte_rx = 1; ev_byte_is_addr = 1; step();
    chk("R4 master addr no set", rx_full, 0);

    // R5/R6 slave
    mode_slave = 1;
    ev_byte_rx = 1; ev_byte_is_addr = 1; ev_addr_match = 1; ev_match_rd = 1; step();
    chk("R5 addr byte quiet", rx_full, 0);
    chk("R6 hit set", addr_hit, 1); chk("R6 dir read", dir_read, 1);
    ev_byte_rx = 1; step();
    chk("R5 data after match", rx_full, 1);
    host_status_rd = 1; step();
    chk("R7 status clears rx", rx_full, 0); chk("R7 status clears hit", addr_hit, 0);
    ev_byte_rx = 1; ev_byte_is_addr = 1; step();
    chk("R6 no hit on miss", addr_hit, 0);
    ev_byte_rx = 1; step();
    chk("R5 data after miss", rx_full, 0);
    mode_all_rx = 1;
    ev_byte_rx = 1; ev_byte_is_addr = 1; step();
    chk("R5 all-rx addr", rx_full, 1);
    ev_byte_rx = 1; host_status_rd = 1; step();
    chk("R7 set wins", rx_full, 1);
    host_status_rd = 1; step();
    mode_all_rx = 0;

    // R9 timer mode
    ctl_enable = 0; step();
    brg_tick = 1; ev_data_first = 1; ev_byte_rx = 1; step();
    chk("R9 irq tick", irq, 1);
    chk("R9 no tx set", tx_empty, 0); chk("R9 no rx set", rx_full, 0);
    step();
    chk("R9 irq drop", irq, 0);

    // random phase against model
    do_reset();
    for (int i = 0; i < 20000; i++) begin
      chk("R2 tx_empty", tx_empty, m_tx);
      chk("R5 rx_full", rx_full, m_rx);
      chk("R6 addr_hit", addr_hit, m_hit);
      chk("R6 dir_read", dir_read, m_dir);
      chk("R8 irq", irq, m_irq);
      ctl_enable  = ($urandom % 16) != 0;
      txe_irq_en  = ($urandom % 8) != 0;
      if ($urandom % 32 == 0) mode_slave  = ~mode_slave;
      if ($urandom % 64 == 0) mode_all_rx = ~mode_all_rx;
      ev_data_first      = ($urandom % 8) == 0;
      ev_addr10_first    = ($urandom % 10) == 0;
      ev_addr_last_first = ($urandom % 10) == 0;
      ev_addr_rd         = $urandom % 2;
      ev_byte_rx         = ($urandom % 5) == 0;
      ev_byte_is_addr    = ($urandom % 3) == 0;
      ev_addr_match      = $urandom % 2;
      ev_match_rd        = $urandom % 2;
      host_status_rd     = ($urandom % 6) == 0;
      host_data_rd       = ($urandom % 6) == 0;
      host_data_wr       = ($urandom % 7) == 0;
      brg_tick           = ($urandom % 4) == 0;
      model_update();
      @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule